// File: doc/BRIEF.md
# Remote FIFO Space Credit Cache

This block sits on the central side of a distributed timed-I/O link and decides, for each outgoing output event aimed at a remote channel, whether the event may go out now. It holds one cached count of free slots per remote channel event FIFO. An event on a channel whose cached count is nonzero leaves at once as an event packet, and that count drops by one. When the cached count is zero, the block sends a space query for that channel and overwrites the cache with the answer. It keeps querying until the answer shows at least one free slot, then sends the event.

Before any credit is consulted, each request is screened. A request whose timestamp is not later than the current time plus a fixed minimum lead is an underflow. A request whose timestamp is earlier than the last event actually sent on the same channel is a sequence error. Either one rejects the event: no packet of any kind goes out, the cache is left alone, and a status pulse reports the reason. Only one query is ever outstanding, and the requester sees a busy flag from the query until the event is sent.

Top module: `fifo_credit_cache`

## Requirements
- R1: After reset every cached count is zero, every per-channel last-sent timestamp is zero, `req_busy` is low and no output strobe is raised, so the first valid event on any channel issues a space query.
- R2: A request accepted while `req_busy` is low, passing both screens, on a channel with a nonzero cached count raises `ev_valid` in the next cycle with the request's timestamp, channel, address and data, and decrements that channel's count by one.
- R3: A request passing both screens on a channel whose cached count is zero raises `qry_valid` in the next cycle with `qry_chan` equal to the request channel, and `req_busy` stays high from that cycle until the event is sent.
- R4: While busy, a reply (`rep_valid`) with nonzero `rep_space` sends the pending event in the next cycle, clears `req_busy`, and leaves the cached count at `rep_space - 1`.
- R5: While busy, a reply with `rep_space` of zero raises `qry_valid` again in the next cycle for the same channel and sends no event; this repeats until a nonzero reply arrives.
- R6: A request with timestamp less than or equal to `now_ts + MIN_LEAD` (unsigned, no wrap) is an underflow: no event and no query are produced, `st_code` is 2 in the next cycle, and no cached count changes. Underflow takes precedence over a sequence error.
- R7: A request with timestamp strictly less than the timestamp of the last event sent on the same channel is a sequence error: no event and no query, `st_code` is 3 in the next cycle, no cached count changes. An equal timestamp is accepted.
- R8: Every request produces exactly one `st_valid` pulse; `st_code` 1 means sent and coincides with `ev_valid`, and `st_valid` is never raised with `st_code` 0.
- R9: Cached counts and last-sent timestamps are kept per channel; traffic on one channel never alters another channel's count or ordering check.
- R10: Rejected requests consume no credit: after an underflow or sequence error, the channel's next valid event is handled exactly as if the rejected one had never arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_ts | input | TS_W | Current time counter |
| req_valid | input | 1 | Event request strobe, taken when `req_busy` is low |
| req_ts | input | TS_W | Event timestamp |
| req_chan | input | CH_W | Remote channel index |
| req_addr | input | ADDR_W | Event address |
| req_data | input | DATA_W | Event data |
| req_busy | output | 1 | High while a query round trip is in progress |
| ev_valid | output | 1 | Event packet strobe |
| ev_ts | output | TS_W | Event packet timestamp |
| ev_chan | output | CH_W | Event packet channel |
| ev_addr | output | ADDR_W | Event packet address |
| ev_data | output | DATA_W | Event packet data |
| qry_valid | output | 1 | Space query packet strobe |
| qry_chan | output | CH_W | Channel being queried |
| rep_valid | input | 1 | Space reply strobe |
| rep_space | input | CNT_W | Free slots reported by the remote FIFO |
| st_valid | output | 1 | Outcome strobe, one per request |
| st_code | output | 2 | Outcome: 1 sent, 2 underflow, 3 sequence error |

## Verification
On every cycle the properties check that a sent event always carries the sent code, that a status pulse never carries code 0, that a query only appears while busy, that a zero reply leads straight to another query and a nonzero reply to an event, and that an underflowing request produces only an underflow status. Whether the cache really holds the right count per channel, that rejected requests leave it untouched, that the event fields are carried unchanged through a query round trip, and that the ordering check compares against the last sent timestamp of the right channel can only be shown by the bench's scenarios, which track a model of every channel's credit and last timestamp.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    // Outcome codes reported on st_code
    typedef enum logic [1:0] {
        ST_NONE      = 2'd0,
        ST_SENT      = 2'd1,
        ST_UNDERFLOW = 2'd2,
        ST_SEQERR    = 2'd3
    } status_e;

    // Controller phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    // Combine the two screens; underflow wins over ordering.
    function automatic status_e screen_verdict(input logic too_late, input logic out_of_order);
        if (too_late)
            return ST_UNDERFLOW;
        else if (out_of_order)
            return ST_SEQERR;
        else
            return ST_NONE;
    endfunction

endpackage

// File: rtl/fcc_credit_store.sv
module fcc_credit_store #(
    parameter int NCHAN = 8,
    parameter int CNT_W = 8,
    parameter int TS_W  = 32,
    parameter int CH_W  = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [CNT_W-1:0] rd_credit,
    output logic [TS_W-1:0]  rd_last,
    input  logic             cr_we,
    input  logic [CH_W-1:0]  cr_chan,
    input  logic [CNT_W-1:0] cr_val,
    input  logic             ts_we,
    input  logic [CH_W-1:0]  ts_chan,
    input  logic [TS_W-1:0]  ts_val
);

    logic [CNT_W-1:0] credit [NCHAN];
    logic [TS_W-1:0]  last   [NCHAN];

    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                credit[g] <= '0;
                last[g]   <= '0;
            end else begin
                if (cr_we && (cr_chan == CH_W'(g)))
                    credit[g] <= cr_val;
                if (ts_we && (ts_chan == CH_W'(g)))
                    last[g] <= ts_val;
            end
        end
    end

    assign rd_credit = credit[rd_chan];
    assign rd_last   = last[rd_chan];

endmodule

// File: rtl/fcc_screen.sv
module fcc_screen
    import fcc_pkg::*;
#(
    parameter int TS_W     = 32,
    parameter int MIN_LEAD = 4
) (
    input  logic [TS_W-1:0] cand_ts,
    input  logic [TS_W-1:0] now_ts,
    input  logic [TS_W-1:0] last_ts,
    output status_e         verdict
);

    localparam int SUM_W = TS_W + 1;

    logic [SUM_W-1:0] horizon;
    logic             too_late;
    logic             out_of_order;

    always_comb begin
        horizon      = {1'b0, now_ts} + SUM_W'(MIN_LEAD);
        too_late     = ({1'b0, cand_ts} <= horizon);
        out_of_order = (cand_ts < last_ts);
        verdict      = screen_verdict(too_late, out_of_order);
    end

endmodule

// File: rtl/fifo_credit_cache.sv
module fifo_credit_cache
    import fcc_pkg::*;
#(
    parameter int NCHAN    = 8,
    parameter int CNT_W    = 8,
    parameter int TS_W     = 32,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int MIN_LEAD = 4,
    parameter int CH_W     = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TS_W-1:0]   now_ts,
    input  logic              req_valid,
    input  logic [TS_W-1:0]   req_ts,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_busy,
    output logic              ev_valid,
    output logic [TS_W-1:0]   ev_ts,
    output logic [CH_W-1:0]   ev_chan,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] ev_data,
    output logic              qry_valid,
    output logic [CH_W-1:0]   qry_chan,
    input  logic              rep_valid,
    input  logic [CNT_W-1:0]  rep_space,
    output logic              st_valid,
    output logic [1:0]        st_code
);

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [CH_W-1:0]   chan;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } event_t;

    phase_e  phase;
    event_t  pend;
    event_t  incoming;
    event_t  ev_q;
    status_e st_q;

    logic [CH_W-1:0]  rd_chan;
    logic [CNT_W-1:0] rd_credit;
    logic [TS_W-1:0]  rd_last;
    status_e          verdict;

    logic             cr_we;
    logic [CNT_W-1:0] cr_val;
    logic             ts_we;
    logic             accept;
    logic             reply_in;

    assign incoming = '{ts: req_ts, chan: req_chan, addr: req_addr, data: req_data};
    assign accept   = req_valid && (phase == PH_IDLE);
    assign reply_in = rep_valid && (phase == PH_WAIT);
    assign rd_chan  = (phase == PH_IDLE) ? req_chan : pend.chan;

    fcc_credit_store #(
        .NCHAN (NCHAN),
        .CNT_W (CNT_W),
        .TS_W  (TS_W),
        .CH_W  (CH_W)
    ) i_store (
        .clk       (clk),
        .rst       (rst),
        .rd_chan   (rd_chan),
        .rd_credit (rd_credit),
        .rd_last   (rd_last),
        .cr_we     (cr_we),
        .cr_chan   (rd_chan),
        .cr_val    (cr_val),
        .ts_we     (ts_we),
        .ts_chan   (rd_chan),
        .ts_val    ((phase == PH_IDLE) ? req_ts : pend.ts)
    );

    fcc_screen #(
        .TS_W     (TS_W),
        .MIN_LEAD (MIN_LEAD)
    ) i_screen (
        .cand_ts (req_ts),
        .now_ts  (now_ts),
        .last_ts (rd_last),
        .verdict (verdict)
    );

    // Cache updates: spend a credit on an immediate send, reload from a reply.
    always_comb begin
        cr_we  = 1'b0;
        cr_val = '0;
        ts_we  = 1'b0;
        if (accept && (verdict == ST_NONE) && (rd_credit != '0)) begin
            cr_we  = 1'b1;
            cr_val = rd_credit - CNT_W'(1);
            ts_we  = 1'b1;
        end else if (reply_in) begin
            cr_we  = 1'b1;
            cr_val = (rep_space != '0) ? (rep_space - CNT_W'(1)) : '0;
            ts_we  = (rep_space != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            pend      <= '0;
            ev_q      <= '0;
            ev_valid  <= 1'b0;
            qry_valid <= 1'b0;
            qry_chan  <= '0;
            st_valid  <= 1'b0;
            st_q      <= ST_NONE;
        end else begin
            ev_valid  <= 1'b0;
            qry_valid <= 1'b0;
            st_valid  <= 1'b0;
            st_q      <= ST_NONE;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        pend <= incoming;
                        if (verdict != ST_NONE) begin
                            st_valid <= 1'b1;
                            st_q     <= verdict;
                        end else if (rd_credit != '0) begin
                            ev_q     <= incoming;
                            ev_valid <= 1'b1;
                            st_valid <= 1'b1;
                            st_q     <= ST_SENT;
                        end else begin
                            qry_valid <= 1'b1;
                            qry_chan  <= req_chan;
                            phase     <= PH_WAIT;
                        end
                    end
                end
                PH_WAIT: begin
                    if (rep_valid) begin
                        if (rep_space != '0) begin
                            ev_q     <= pend;
                            ev_valid <= 1'b1;
                            st_valid <= 1'b1;
                            st_q     <= ST_SENT;
                            phase    <= PH_IDLE;
                        end else begin
                            qry_valid <= 1'b1;
                            qry_chan  <= pend.chan;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign req_busy = (phase == PH_WAIT);
    assign ev_ts    = ev_q.ts;
    assign ev_chan  = ev_q.chan;
    assign ev_addr  = ev_q.addr;
    assign ev_data  = ev_q.data;
    assign st_code  = st_q;

endmodule

// File: rtl/fcc_props.sv
module fcc_props #(
    parameter int TS_W     = 32,
    parameter int CNT_W    = 8,
    parameter int MIN_LEAD = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [TS_W-1:0]  now_ts,
    input logic             req_valid,
    input logic [TS_W-1:0]  req_ts,
    input logic             req_busy,
    input logic             ev_valid,
    input logic             qry_valid,
    input logic             rep_valid,
    input logic [CNT_W-1:0] rep_space,
    input logic             st_valid,
    input logic [1:0]       st_code
);

    localparam int SUM_W = TS_W + 1;

    logic late_req;
    assign late_req = req_valid && !req_busy &&
                      ({1'b0, req_ts} <= ({1'b0, now_ts} + SUM_W'(MIN_LEAD)));

    // R8: a sent event always comes with the sent code
    a_r8_event_has_sent_code: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (st_valid && st_code == 2'd1));

    // R8: a status pulse never carries the empty code
    a_r8_status_nonempty: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (st_code != 2'd0));

    // R3: a query only goes out while the requester is held
    a_r3_query_while_busy: assert property (@(posedge clk) disable iff (rst)
        qry_valid |-> (req_busy && !ev_valid && !st_valid));

    // R5: an empty reply leads straight to another query
    a_r5_empty_reply_requery: assert property (@(posedge clk) disable iff (rst)
        (req_busy && rep_valid && rep_space == '0) |=> (qry_valid && !ev_valid));

    // R4: a nonzero reply releases the pending event
    a_r4_reply_releases: assert property (@(posedge clk) disable iff (rst)
        (req_busy && rep_valid && rep_space != '0) |=> (ev_valid && !req_busy));

    // R6: an underflowing request yields only the underflow status
    a_r6_underflow_rejected: assert property (@(posedge clk) disable iff (rst)
        late_req |=> (st_valid && st_code == 2'd2 && !ev_valid && !qry_valid));

endmodule

bind fifo_credit_cache fcc_props #(
    .TS_W     (TS_W),
    .CNT_W    (CNT_W),
    .MIN_LEAD (MIN_LEAD)
) i_props (
    .clk       (clk),
    .rst       (rst),
    .now_ts    (now_ts),
    .req_valid (req_valid),
    .req_ts    (req_ts),
    .req_busy  (req_busy),
    .ev_valid  (ev_valid),
    .qry_valid (qry_valid),
    .rep_valid (rep_valid),
    .rep_space (rep_space),
    .st_valid  (st_valid),
    .st_code   (st_code)
);

// File: tb/test_fifo_credit_cache.sv
module test_fifo_credit_cache;

    localparam int NCHAN    = 8;
    localparam int CNT_W    = 8;
    localparam int TS_W     = 32;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int MIN_LEAD = 4;
    localparam int CH_W     = $clog2(NCHAN);

    localparam int K_EV  = 1;
    localparam int K_QRY = 2;
    localparam int K_UF  = 3;
    localparam int K_SE  = 4;
    localparam int K_BAD = 5;

    typedef struct {
        int          kind;
        logic [31:0] ts;
        int          ch;
        logic [7:0]  addr;
        logic [31:0] data;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [TS_W-1:0]   now_ts = '0;
    logic              req_valid = 1'b0;
    logic [TS_W-1:0]   req_ts = '0;
    logic [CH_W-1:0]   req_chan = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              req_busy;
    logic              ev_valid;
    logic [TS_W-1:0]   ev_ts;
    logic [CH_W-1:0]   ev_chan;
    logic [ADDR_W-1:0] ev_addr;
    logic [DATA_W-1:0] ev_data;
    logic              qry_valid;
    logic [CH_W-1:0]   qry_chan;
    logic              rep_valid = 1'b0;
    logic [CNT_W-1:0]  rep_space = '0;
    logic              st_valid;
    logic [1:0]        st_code;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    item_t exp_q[$];
    int    m_credit [NCHAN];
    longint m_last  [NCHAN];

    always #2 clk = ~clk;

    always @(posedge clk) begin
        now_ts <= now_ts + 1;
        cycles <= cycles + 1;
    end

    fifo_credit_cache #(
        .NCHAN(NCHAN), .CNT_W(CNT_W), .TS_W(TS_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .MIN_LEAD(MIN_LEAD), .CH_W(CH_W)
    ) i_fifo_credit_cache (
        .clk(clk), .rst(rst), .now_ts(now_ts),
        .req_valid(req_valid), .req_ts(req_ts), .req_chan(req_chan),
        .req_addr(req_addr), .req_data(req_data), .req_busy(req_busy),
        .ev_valid(ev_valid), .ev_ts(ev_ts), .ev_chan(ev_chan),
        .ev_addr(ev_addr), .ev_data(ev_data),
        .qry_valid(qry_valid), .qry_chan(qry_chan),
        .rep_valid(rep_valid), .rep_space(rep_space),
        .st_valid(st_valid), .st_code(st_code)
    );

    // Monitor: pops the scoreboard whenever the design emits anything
    always @(negedge clk) begin
        if (!rst && (ev_valid || qry_valid || st_valid)) begin
            item_t o;
            item_t e;
            o.ts = ev_ts; o.ch = int'(ev_chan); o.addr = ev_addr; o.data = ev_data;
            o.tag = "";
            if (qry_valid && (ev_valid || st_valid)) o.kind = K_BAD;
            else if (qry_valid) begin o.kind = K_QRY; o.ch = int'(qry_chan); end
            else if (ev_valid && st_valid && st_code == 2'd1) o.kind = K_EV;
            else if (!ev_valid && st_valid && st_code == 2'd2) o.kind = K_UF;
            else if (!ev_valid && st_valid && st_code == 2'd3) o.kind = K_SE;
            else o.kind = K_BAD;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R8: unexpected output kind %0d ch %0d, expected nothing", o.kind, o.ch);
            end else begin
                e = exp_q.pop_front();
                if (o.kind != e.kind ||
                    ((e.kind == K_EV || e.kind == K_QRY) && o.ch != e.ch) ||
                    (e.kind == K_EV && (o.ts != e.ts || o.addr != e.addr || o.data != e.data))) begin
                    n_fails++;
                    $display("FAIL %s: got kind %0d ch %0d ts %0h addr %0h data %0h, expected kind %0d ch %0d ts %0h addr %0h data %0h",
                             e.tag, o.kind, o.ch, o.ts, o.addr, o.data,
                             e.kind, e.ch, e.ts, e.addr, e.data);
                end
            end
        end
    end

    task automatic push_item(input int kind, input logic [31:0] ts, input int ch,
                             input logic [7:0] addr, input logic [31:0] data, input string tag);
        item_t it;
        it.kind = kind; it.ts = ts; it.ch = ch; it.addr = addr; it.data = data; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Driver: predicts the outcome, drives one request, answers queries.
    // use_abs=0: ts = now + val; use_abs=1: ts = val.
    task automatic send(input bit use_abs, input longint val, input int ch,
                        input logic [7:0] addr, input logic [31:0] data,
                        input int nzero, input int space, input string tag);
        longint ts;
        bit     uf;
        bit     se;
        bit     need_q;
        @(negedge clk);
        while (req_busy) @(negedge clk);
        ts = use_abs ? val : (longint'(now_ts) + val);
        uf = (ts <= longint'(now_ts) + MIN_LEAD);
        se = (ts < m_last[ch]);
        need_q = 1'b0;
        if (uf) push_item(K_UF, ts[31:0], ch, addr, data, tag);
        else if (se) push_item(K_SE, ts[31:0], ch, addr, data, tag);
        else if (m_credit[ch] > 0) begin
            push_item(K_EV, ts[31:0], ch, addr, data, tag);
            m_credit[ch]--;
            m_last[ch] = ts;
        end else begin
            need_q = 1'b1;
            for (int i = 0; i <= nzero; i++) push_item(K_QRY, '0, ch, '0, '0, tag);
            push_item(K_EV, ts[31:0], ch, addr, data, tag);
            m_credit[ch] = space - 1;
            m_last[ch] = ts;
        end
        req_valid = 1'b1; req_ts = ts[31:0]; req_chan = CH_W'(ch);
        req_addr = addr; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        if (need_q) begin
            for (int i = 0; i <= nzero; i++) begin
                while (!qry_valid) @(negedge clk);
                n_checks++;
                if (!req_busy) begin
                    n_fails++;
                    $display("FAIL R3: req_busy %0b during query, expected 1", req_busy);
                end
                rep_valid = 1'b1;
                rep_space = (i < nzero) ? '0 : CNT_W'(space);
                @(negedge clk);
                rep_valid = 1'b0;
            end
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < NCHAN; c++) begin m_credit[c] = 0; m_last[c] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (req_busy || ev_valid || qry_valid || st_valid) begin
            n_fails++;
            $display("FAIL R1: busy %0b ev %0b qry %0b st %0b, expected all 0",
                     req_busy, ev_valid, qry_valid, st_valid);
        end
        // R1 R3 R4: first event on channel 0 forces a query, reply 3
        send(1'b0, 100, 0, 8'h11, 32'hA000_0001, 0, 3, "R4");
        // R2: credit 2 left, immediate send
        send(1'b0, 150, 0, 8'h12, 32'hA000_0002, 0, 1, "R2");
        // R6: timestamp at the boundary now + MIN_LEAD
        send(1'b0, MIN_LEAD, 0, 8'h13, 32'hA000_0003, 0, 1, "R6");
        // R6: timestamp in the past
        send(1'b0, -3, 0, 8'h14, 32'hA000_0004, 0, 1, "R6");
        // R7: earlier than last sent on channel 0
        send(1'b1, m_last[0] - 1, 0, 8'h15, 32'hA000_0005, 0, 1, "R7");
        // R10: rejects spent nothing, last credit sends at once; R7 equal timestamp allowed
        send(1'b1, m_last[0], 0, 8'h16, 32'hA000_0006, 0, 1, "R10");
        // R5: credit exhausted, two empty replies then one slot
        send(1'b0, 300, 0, 8'h17, 32'hA000_0007, 2, 1, "R5");
        // R9: channel 3 untouched so far, queries independently
        send(1'b0, 50, 3, 8'h31, 32'hB000_0001, 0, 2, "R9");
        // R9: channel 3 ordering checked against its own last timestamp, not channel 0
        send(1'b0, 60, 3, 8'h32, 32'hB000_0002, 0, 1, "R9");
        // R3: channel 0 is back to zero credit
        send(1'b0, 400, 0, 8'h18, 32'hA000_0008, 0, 5, "R3");
        // R6: both late and out of order reports underflow
        send(1'b0, 1, 3, 8'h33, 32'hB000_0003, 0, 1, "R6");
        // R1: highest channel also starts empty
        send(1'b0, 20, NCHAN - 1, 8'h71, 32'hC000_0001, 1, 4, "R1");
        // R2: back-to-back sends from cache on the highest channel
        send(1'b0, 30, NCHAN - 1, 8'h72, 32'hC000_0002, 0, 1, "R2");
        send(1'b0, 40, NCHAN - 1, 8'h73, 32'hC000_0003, 0, 1, "R2");
        // R7: sequence error on the highest channel
        send(1'b1, m_last[NCHAN - 1] - 5, NCHAN - 1, 8'h74, 32'hC000_0004, 0, 1, "R7");
        repeat (4) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R8: %0d outputs missing, expected 0", exp_q.size());
        end
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 100000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R8: watchdog expired at cycle %0d, expected completion", cycles);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule